// File: doc/BRIEF.md
# Indirect Configuration and I/O Access Port

This block sits between a CPU register interface and a PCI host bridge core. Software first writes a target address into a 32-bit pointer register. It then reads or writes one of two data windows. The configuration window turns each access into a configuration transaction. The I/O window turns each access into an I/O-space transaction. Each window access produces exactly one downstream request. That request carries a combined address, the access size, the direction and the write data. The CPU response is held back until the downstream side completes.

The two windows build the address differently. The configuration window ORs the byte offset of the access into the pointer. The I/O window adds the offset to the pointer. The two windows also use opposite byte orders. Configuration data passes through in little-endian lane order. I/O data of 16 and 32 bits is byte-reversed. Sub-word data is right-justified on both the CPU bus and the downstream bus.

The configuration window accepts any size at any offset. The I/O window only accepts naturally aligned accesses. The pointer register only accepts full-word accesses at offset 0. A rejected access returns an error with all-ones read data and sends nothing downstream.

Top module: `cfgio_port`

## Requirements
- R1: The pointer register (window code 0) accepts only a word access (size code 2) at offset 0. A write stores the data with bits [1:0] cleared. A read returns the stored value. Any other size or offset is rejected and leaves the register unchanged.
- R2: A configuration window access (window code 1) issues a request with dn_io_o = 0 and address = pointer OR offset. The request is issued whether or not pointer bit 31 is set.
- R3: An I/O window access (window code 2) issues a request with dn_io_o = 1 and address = pointer + offset.
- R4: Configuration data keeps its lane order. Write data is the low 1, 2 or 4 bytes of cpu_wdata_i, and the upper bytes are zero.
- R5: For I/O halfword and word accesses, the bytes are reversed in both directions. For example, CPU 0x01020304 becomes 0x04030201 downstream. A byte access is not swapped.
- R6: In the I/O window, a byte access is legal at offsets 0 to 3, a halfword at offsets 0 and 2, and a word only at offset 0. Any other combination is rejected.
- R7: dn_valid_o stays asserted, with stable fields, until dn_ready_i is high. cpu_rsp_o pulses for one cycle, in the cycle after dn_done_i is sampled, and never earlier.
- R8: Read data returned from a window holds only the accessed size, right-justified, with the upper bits zero. A write returns zero read data.
- R9: After reset, the pointer reads 0, and dn_valid_o and cpu_rsp_o are low.
- R10: Size code 3 on any window is rejected, and so is window code 3. A rejected access sets cpu_err_o, returns 0xFFFFFFFF and issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Access request; fields held until cpu_rsp_o |
| cpu_we_i | input | 1 | 1 = write |
| cpu_win_i | input | 2 | 0 pointer, 1 config data, 2 I/O data, 3 none |
| cpu_size_i | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| cpu_off_i | input | 2 | Byte offset within the window |
| cpu_wdata_i | input | 32 | Right-justified write data |
| cpu_rsp_o | output | 1 | One-cycle response strobe |
| cpu_err_o | output | 1 | Access rejected (valid with cpu_rsp_o) |
| cpu_rdata_o | output | 32 | Right-justified read data (valid with cpu_rsp_o) |
| dn_valid_o | output | 1 | Downstream request valid |
| dn_ready_i | input | 1 | Downstream request accepted |
| dn_io_o | output | 1 | 1 = I/O space, 0 = configuration space |
| dn_we_o | output | 1 | Downstream direction |
| dn_size_o | output | 2 | Downstream size code |
| dn_addr_o | output | AW | Combined target address |
| dn_wdata_o | output | 32 | Right-justified, lane-ordered write data |
| dn_done_i | input | 1 | Read data or write acknowledge returned |
| dn_rdata_i | input | 32 | Right-justified downstream read data |

## Verification
Configuration reads and writes are driven with pointer bit 31 both set and clear, and at unaligned offsets. This separates OR-combining from any gating on the enable bit.

I/O accesses use each size at legal offsets, with distinct byte values in every lane. A missing swap, a swap applied to a byte access, or a wrong mask each shows up as a different value.

Misaligned I/O accesses, size code 3, window code 3 and a halfword access to the pointer register check that rejection issues nothing and leaves the pointer intact.

A stalled ready checks that the request holds steady and that the response waits for completion.

// File: rtl/cfgio_pkg.sv
package cfgio_pkg;
  localparam int DW = 32;
  localparam int NB = DW / 8;

  typedef enum logic [1:0] {WIN_PTR = 2'd0, WIN_CFG = 2'd1, WIN_IO = 2'd2, WIN_NONE = 2'd3} win_e;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_BAD = 2'd3} size_e;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_RESP} state_e;
endpackage

// File: rtl/cfgio_decode.sv
module cfgio_decode
  import cfgio_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [1:0]    win_i,
  input  logic [1:0]    size_i,
  input  logic [1:0]    off_i,
  input  logic [AW-1:0] base_i,
  output logic          legal_o,
  output logic          to_dn_o,
  output logic          is_io_o,
  output logic [AW-1:0] addr_o
);
  win_e  win;
  size_e sz;
  assign win = win_e'(win_i);
  assign sz  = size_e'(size_i);

  always_comb begin
    legal_o = 1'b0;
    unique case (win)
      WIN_PTR:  legal_o = (sz == SZ_WORD) && (off_i == 2'd0);
      WIN_CFG:  legal_o = (sz != SZ_BAD);
      WIN_IO: begin
        unique case (sz)
          SZ_BYTE: legal_o = 1'b1;
          SZ_HALF: legal_o = ~off_i[0];
          SZ_WORD: legal_o = (off_i == 2'd0);
          default: legal_o = 1'b0;
        endcase
      end
      default:  legal_o = 1'b0;
    endcase
  end

  assign is_io_o = (win == WIN_IO);
  assign to_dn_o = legal_o && (win != WIN_PTR);
  // I/O window adds the offset, config window ORs it
  assign addr_o  = is_io_o ? base_i + AW'(off_i) : base_i | AW'(off_i);
endmodule

// File: rtl/cfgio_lanes.sv
module cfgio_lanes
  import cfgio_pkg::*;
(
  input  logic [DW-1:0] data_i,
  input  logic [1:0]    size_i,
  input  logic          swap_i,
  output logic [DW-1:0] data_o
);
  int nb;

  always_comb begin
    unique case (size_i)
      2'd0:    nb = 1;
      2'd1:    nb = 2;
      default: nb = NB;
    endcase
  end

  for (genvar g = 0; g < NB; g++) begin : g_lane
    always_comb begin
      if (g >= nb)      data_o[8*g +: 8] = 8'h00;
      else if (swap_i)  data_o[8*g +: 8] = data_i[8*(nb-1-g) +: 8];
      else              data_o[8*g +: 8] = data_i[8*g +: 8];
    end
  end
endmodule

// File: rtl/cfgio_port.sv
module cfgio_port
  import cfgio_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpu_req_i,
  input  logic          cpu_we_i,
  input  logic [1:0]    cpu_win_i,
  input  logic [1:0]    cpu_size_i,
  input  logic [1:0]    cpu_off_i,
  input  logic [31:0]   cpu_wdata_i,
  output logic          cpu_rsp_o,
  output logic          cpu_err_o,
  output logic [31:0]   cpu_rdata_o,
  output logic          dn_valid_o,
  input  logic          dn_ready_i,
  output logic          dn_io_o,
  output logic          dn_we_o,
  output logic [1:0]    dn_size_o,
  output logic [AW-1:0] dn_addr_o,
  output logic [31:0]   dn_wdata_o,
  input  logic          dn_done_i,
  input  logic [31:0]   dn_rdata_i
);
  state_e        state_q;
  logic [AW-1:0] ptr_q, addr_q;
  logic          io_q, we_q, err_q;
  logic [1:0]    size_q;
  logic [DW-1:0] wdata_q, rdata_q;

  logic          legal, to_dn, is_io;
  logic [AW-1:0] dec_addr;
  logic [DW-1:0] wd_lane, rd_lane;

  cfgio_decode #(.AW(AW)) i_decode (
    .win_i   (cpu_win_i),
    .size_i  (cpu_size_i),
    .off_i   (cpu_off_i),
    .base_i  (ptr_q),
    .legal_o (legal),
    .to_dn_o (to_dn),
    .is_io_o (is_io),
    .addr_o  (dec_addr)
  );

  cfgio_lanes i_wr_lanes (
    .data_i (cpu_wdata_i),
    .size_i (cpu_size_i),
    .swap_i (is_io),
    .data_o (wd_lane)
  );

  cfgio_lanes i_rd_lanes (
    .data_i (dn_rdata_i),
    .size_i (size_q),
    .swap_i (io_q),
    .data_o (rd_lane)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      addr_q  <= '0;
      io_q    <= 1'b0;
      we_q    <= 1'b0;
      err_q   <= 1'b0;
      size_q  <= 2'd0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (cpu_req_i) begin
          err_q <= ~legal;
          if (!legal) begin
            rdata_q <= '1;
            state_q <= ST_RESP;
          end else if (!to_dn) begin
            if (cpu_we_i) ptr_q <= {cpu_wdata_i[AW-1:2], 2'b00};
            rdata_q <= cpu_we_i ? '0 : DW'(ptr_q);
            state_q <= ST_RESP;
          end else begin
            io_q    <= is_io;
            we_q    <= cpu_we_i;
            size_q  <= cpu_size_i;
            addr_q  <= dec_addr;
            wdata_q <= cpu_we_i ? wd_lane : '0;
            rdata_q <= '0;
            state_q <= ST_REQ;
          end
        end
        ST_REQ: if (dn_ready_i) begin
          if (dn_done_i) begin
            rdata_q <= we_q ? '0 : rd_lane;
            state_q <= ST_RESP;
          end else begin
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: if (dn_done_i) begin
          rdata_q <= we_q ? '0 : rd_lane;
          state_q <= ST_RESP;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cpu_rsp_o   = (state_q == ST_RESP);
  assign cpu_err_o   = err_q;
  assign cpu_rdata_o = rdata_q;
  assign dn_valid_o  = (state_q == ST_REQ);
  assign dn_io_o     = io_q;
  assign dn_we_o     = we_q;
  assign dn_size_o   = size_q;
  assign dn_addr_o   = addr_q;
  assign dn_wdata_o  = wdata_q;

  AST_PTR_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q[1:0] == 2'b00); // R1
  AST_IO_WORD_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_valid_o && dn_io_o && dn_size_o == 2'd2 |-> dn_addr_o[1:0] == ptr_q[1:0]); // R6
  AST_NO_BAD_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_valid_o |-> dn_size_o != 2'd3); // R10
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_valid_o && !dn_ready_i |=> dn_valid_o && $stable(dn_addr_o) && $stable(dn_wdata_o)); // R7
  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rsp_o |=> !cpu_rsp_o); // R7
  AST_ERR_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rsp_o && cpu_err_o |-> !$past(dn_valid_o)); // R10
endmodule

// File: tb/test_cfgio_port.sv
module test_cfgio_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_i = 0, cpu_we_i = 0;
  logic [1:0]  cpu_win_i = 0, cpu_size_i = 0, cpu_off_i = 0;
  logic [31:0] cpu_wdata_i = 0;
  logic        cpu_rsp_o, cpu_err_o;
  logic [31:0] cpu_rdata_o;
  logic        dn_valid_o, dn_io_o, dn_we_o;
  logic        dn_ready_i = 0, dn_done_i = 0;
  logic [1:0]  dn_size_o;
  logic [31:0] dn_addr_o, dn_wdata_o;
  logic [31:0] dn_rdata_i = 0;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cfgio_port i_cfgio_port (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i, .cpu_we_i, .cpu_win_i, .cpu_size_i, .cpu_off_i, .cpu_wdata_i,
    .cpu_rsp_o, .cpu_err_o, .cpu_rdata_o,
    .dn_valid_o, .dn_ready_i, .dn_io_o, .dn_we_o, .dn_size_o, .dn_addr_o,
    .dn_wdata_o, .dn_done_i, .dn_rdata_i
  );

  typedef struct packed {
    logic [31:0] base;
    logic [1:0]  win;
    logic        we;
    logic [1:0]  size;
    logic [1:0]  off;
    logic [31:0] wdata;
    logic [31:0] dnr;
    logic        iss;
    logic [31:0] daddr;
    logic [31:0] dwd;
    logic [31:0] rd;
    logic        err;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{32'h8000_1230, 2'd1, 1'b0, 2'd2, 2'd0, 32'h0, 32'h1122_3344, 1'b1, 32'h8000_1230, 32'h0, 32'h1122_3344, 1'b0},
    '{32'h0000_0A40, 2'd1, 1'b0, 2'd0, 2'd3, 32'h0, 32'hFFFF_FFAB, 1'b1, 32'h0000_0A43, 32'h0, 32'h0000_00AB, 1'b0},
    '{32'h0000_0810, 2'd1, 1'b1, 2'd1, 2'd2, 32'hDEAD_BEEF, 32'h0, 1'b1, 32'h0000_0812, 32'h0000_BEEF, 32'h0, 1'b0},
    '{32'h0000_0100, 2'd1, 1'b0, 2'd1, 2'd1, 32'h0, 32'h5566_7788, 1'b1, 32'h0000_0101, 32'h0, 32'h0000_7788, 1'b0},
    '{32'h0000_03F8, 2'd2, 1'b0, 2'd2, 2'd0, 32'h0, 32'h1122_3344, 1'b1, 32'h0000_03F8, 32'h0, 32'h4433_2211, 1'b0},
    '{32'h0000_02E8, 2'd2, 1'b1, 2'd1, 2'd2, 32'h0000_ABCD, 32'h0, 1'b1, 32'h0000_02EA, 32'h0000_CDAB, 32'h0, 1'b0},
    '{32'h0000_02E8, 2'd2, 1'b1, 2'd0, 2'd3, 32'h1234_5678, 32'h0, 1'b1, 32'h0000_02EB, 32'h0000_0078, 32'h0, 1'b0},
    '{32'h0000_0060, 2'd2, 1'b0, 2'd0, 2'd1, 32'h0, 32'hAABB_CCDD, 1'b1, 32'h0000_0061, 32'h0, 32'h0000_00DD, 1'b0},
    '{32'h0000_0060, 2'd2, 1'b0, 2'd1, 2'd1, 32'h0, 32'h0, 1'b0, 32'h0, 32'h0, 32'hFFFF_FFFF, 1'b1},
    '{32'h0000_0060, 2'd2, 1'b1, 2'd2, 2'd2, 32'h1, 32'h0, 1'b0, 32'h0, 32'h0, 32'hFFFF_FFFF, 1'b1},
    '{32'h0000_0060, 2'd2, 1'b0, 2'd1, 2'd3, 32'h0, 32'h0, 1'b0, 32'h0, 32'h0, 32'hFFFF_FFFF, 1'b1},
    '{32'h0000_0060, 2'd1, 1'b0, 2'd3, 2'd0, 32'h0, 32'h0, 1'b0, 32'h0, 32'h0, 32'hFFFF_FFFF, 1'b1},
    '{32'h0000_0060, 2'd3, 1'b0, 2'd2, 2'd0, 32'h0, 32'h0, 1'b0, 32'h0, 32'h0, 32'hFFFF_FFFF, 1'b1},
    '{32'h0000_1000, 2'd2, 1'b1, 2'd2, 2'd0, 32'h0102_0304, 32'h0, 1'b1, 32'h0000_1000, 32'h0403_0201, 32'h0, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // one CPU access with a modelled downstream responder
  task automatic access(input logic [1:0] win, input logic we, input logic [1:0] size,
                        input logic [1:0] off, input logic [31:0] wd, input logic [31:0] dnr,
                        input int rdly,
                        output logic [31:0] rd, output logic err, output logic iss,
                        output logic [31:0] daddr, output logic [31:0] dwd,
                        output logic dio, output logic dwe, output logic [1:0] dsz,
                        output int vcnt, output logic early);
    int phase = 0, cnt = 0;
    logic done_given = 0;
    bit got = 0;
    iss = 0; vcnt = 0; early = 0; rd = '0; err = 0;
    daddr = '0; dwd = '0; dio = 0; dwe = 0; dsz = 0;
    @(negedge clk);
    cpu_win_i = win; cpu_we_i = we; cpu_size_i = size; cpu_off_i = off;
    cpu_wdata_i = wd; cpu_req_i = 1'b1;
    for (int k = 0; k < 60 && !got; k++) begin
      @(negedge clk);
      dn_ready_i = 1'b0; dn_done_i = 1'b0;
      if (cpu_rsp_o) begin
        rd = cpu_rdata_o; err = cpu_err_o; got = 1;
        if (iss && !done_given) early = 1;
        cpu_req_i = 1'b0;
      end else if (phase == 0 && dn_valid_o) begin
        vcnt++;
        if (vcnt > rdly) begin
          iss = 1; daddr = dn_addr_o; dwd = dn_wdata_o;
          dio = dn_io_o; dwe = dn_we_o; dsz = dn_size_o;
          dn_ready_i = 1'b1; phase = 1; cnt = 2;
        end
      end else if (phase == 1) begin
        cnt--;
        if (cnt == 0) begin
          dn_done_i = 1'b1; dn_rdata_i = dnr; done_given = 1; phase = 2;
        end
      end
    end
    if (!got) begin
      n_run++; n_fail++;
      $display("FAIL R7: no response, got 0 expected 1");
      cpu_req_i = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, daddr, dwd;
    logic err, iss, dio, dwe, early;
    logic [1:0] dsz;
    int vcnt;

    repeat (3) @(negedge clk);
    chk("R9 valid after reset", {31'b0, dn_valid_o}, 32'h0);
    chk("R9 rsp after reset", {31'b0, cpu_rsp_o}, 32'h0);
    rst_n = 1'b1;
    access(2'd0, 1'b0, 2'd2, 2'd0, 32'h0, 32'h0, 0, rd, err, iss, daddr, dwd, dio, dwe, dsz, vcnt, early);
    chk("R9 pointer reset value", rd, 32'h0);
    chk("R1 pointer read no request", {31'b0, iss}, 32'h0);

    // pointer low bits forced to zero
    access(2'd0, 1'b1, 2'd2, 2'd0, 32'hFFFF_FFFF, 32'h0, 0, rd, err, iss, daddr, dwd, dio, dwe, dsz, vcnt, early);
    access(2'd0, 1'b0, 2'd2, 2'd0, 32'h0, 32'h0, 0, rd, err, iss, daddr, dwd, dio, dwe, dsz, vcnt, early);
    chk("R1 pointer low bits cleared", rd, 32'hFFFF_FFFC);
    // halfword write to pointer rejected, value kept
    access(2'd0, 1'b1, 2'd1, 2'd0, 32'h0000_1234, 32'h0, 0, rd, err, iss, daddr, dwd, dio, dwe, dsz, vcnt, early);
    chk("R1 pointer halfword error", {31'b0, err}, 32'h1);
    access(2'd0, 1'b0, 2'd2, 2'd0, 32'h0, 32'h0, 0, rd, err, iss, daddr, dwd, dio, dwe, dsz, vcnt, early);
    chk("R1 pointer unchanged after reject", rd, 32'hFFFF_FFFC);

    for (int i = 0; i < NV; i++) begin
      string t_addr, t_data;
      vec_t v = VEC[i];
      t_addr = v.err ? ((v.size == 2'd3 || v.win == 2'd3) ? "R10" : "R6")
                     : (v.win == 2'd1 ? "R2" : "R3");
      t_data = (v.win == 2'd1) ? "R4" : "R5";
      access(2'd0, 1'b1, 2'd2, 2'd0, v.base, 32'h0, 0, rd, err, iss, daddr, dwd, dio, dwe, dsz, vcnt, early);
      access(v.win, v.we, v.size, v.off, v.wdata, v.dnr, i % 3, rd, err, iss, daddr, dwd, dio, dwe, dsz, vcnt, early);
      chk($sformatf("%s vec%0d err", t_addr, i), {31'b0, err}, {31'b0, v.err});
      chk($sformatf("%s vec%0d issued", t_addr, i), {31'b0, iss}, {31'b0, v.iss});
      chk($sformatf("R8 vec%0d rdata", i), rd, v.rd);
      if (v.iss) begin
        chk($sformatf("%s vec%0d addr", t_addr, i), daddr, v.daddr);
        chk($sformatf("%s vec%0d space", t_addr, i), {31'b0, dio}, {31'b0, v.win == 2'd2});
        chk($sformatf("%s vec%0d size/dir", t_addr, i), {29'b0, dsz, dwe}, {29'b0, v.size, v.we});
        chk($sformatf("%s vec%0d wdata", t_data, i), dwd, v.dwd);
        chk($sformatf("R7 vec%0d valid hold", i), vcnt, (i % 3) + 1);
        chk($sformatf("R7 vec%0d early rsp", i), {31'b0, early}, 32'h0);
      end
    end

    // long ready stall on a config read with bit 31 clear
    access(2'd0, 1'b1, 2'd2, 2'd0, 32'h0000_0004, 32'h0, 0, rd, err, iss, daddr, dwd, dio, dwe, dsz, vcnt, early);
    access(2'd1, 1'b0, 2'd2, 2'd0, 32'h0, 32'hCAFE_F00D, 6, rd, err, iss, daddr, dwd, dio, dwe, dsz, vcnt, early);
    chk("R7 stalled valid cycles", vcnt, 7);
    chk("R7 stalled no early rsp", {31'b0, early}, 32'h0);
    chk("R2 stalled addr", daddr, 32'h0000_0004);
    chk("R4 stalled rdata", rd, 32'hCAFE_F00D);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule